// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block is the top-level operating-state machine of a DRAM protocol controller. Software (or an upstream sequencer) issues state-change commands as a one-cycle `cmd_valid` pulse with a 3-bit command code. The machine reports where it stands through a 3-bit status code that covers three groups of states:

- the stable states: memory init, config, access and low power;
- the request states that sit between the stable states;
- the entry and exit request states around low power.

Each move between stable states first goes to a request state. There the block raises a request to a helper sub-unit and waits for that sub-unit's acknowledge before it settles. Configuration lock and release use one pair of helpers, and self-refresh entry and exit use another pair. In this project those helpers are stubs driven from outside.

Waking from low power always lands in access. Reaching config from low power therefore takes a wakeup command followed by a config command. A command that is not legal in the current state is dropped.

Top module: `mc_opstate`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `status` is 0 (memory init) and all four request outputs are low.
- R2: A config command (code 1) in status 0 or status 3 moves `status` to 2 (config request) on the next clock edge. `cfg_lock_req` rises on that same edge. The first edge that samples `cfg_lock_ack` high in status 2 moves `status` to 1 (config).
- R3: A go command (code 2) in status 1 moves `status` to 4 (access request) and raises `cfg_rel_req`. The first edge that samples `cfg_rel_ack` high in status 4 moves `status` to 3 (access).
- R4: A sleep command (code 3) is taken only in status 3. It moves `status` to 6 (low-power entry request) and raises `sr_enter_req`. An edge that samples `sr_enter_ack` high in status 6 moves `status` to 5 (low power).
- R5: A wakeup command (code 4) in status 5 moves `status` to 7 (low-power exit request) and raises `sr_exit_req`. An edge that samples `sr_exit_ack` high in status 7 moves `status` to 3 (access), never to 1.
- R6: A request state holds while its acknowledge is low. It lasts at least one full cycle even if the acknowledge is already high when the state is entered.
- R7: Commands not listed as legal in R2 to R5 are ignored and leave `status` unchanged. This covers the init command (code 0), codes 5 to 7, and any command given while in a request state.
- R8: Each request output is high exactly while `status` holds its matching request code (`cfg_lock_req` with 2, `cfg_rel_req` with 4, `sr_enter_req` with 6, `sr_exit_req` with 7). At most one request output is high at a time.
- R9: An acknowledge that arrives outside its matching request state has no effect on `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | Command code: 0 init, 1 config, 2 go, 3 sleep, 4 wakeup |
| cfg_lock_ack | input | 1 | Configuration-lock helper acknowledge |
| cfg_rel_ack | input | 1 | Configuration-release helper acknowledge |
| sr_enter_ack | input | 1 | Self-refresh entry helper acknowledge |
| sr_exit_ack | input | 1 | Self-refresh exit helper acknowledge |
| status | output | 3 | Current operating state, codes 0 to 7 as in R1 to R5 |
| cfg_lock_req | output | 1 | Request to the configuration-lock helper |
| cfg_rel_req | output | 1 | Request to the configuration-release helper |
| sr_enter_req | output | 1 | Request to the self-refresh entry helper |
| sr_exit_req | output | 1 | Request to the self-refresh exit helper |

## Verification
Status and the request outputs both come straight from flops. A command or acknowledge sampled at one rising edge is therefore visible exactly one edge later, and a settle takes two edges in total: one to enter the request state and one to leave it on the acknowledge. The bench applies every stimulus at a falling edge, lets one rising edge pass, and compares at the next falling edge. For R6 it holds the acknowledge low for several extra cycles, or high before the request state is entered, and samples after each single edge. Ignored commands and stray acknowledges are followed by a status comparison before any further stimulus.

// File: rtl/mcop_pkg.sv
package mcop_pkg;
  localparam int ST_W  = 3;
  localparam int CMD_W = 3;
  localparam int N_REQ = 4;

  typedef enum logic [ST_W-1:0] {
    ST_INIT    = 3'd0,
    ST_CFG     = 3'd1,
    ST_CFG_REQ = 3'd2,
    ST_ACC     = 3'd3,
    ST_ACC_REQ = 3'd4,
    ST_LP      = 3'd5,
    ST_LP_ENT  = 3'd6,
    ST_LP_EXIT = 3'd7
  } opstate_e;

  localparam logic [CMD_W-1:0] CMD_INIT  = 3'd0;
  localparam logic [CMD_W-1:0] CMD_CFG   = 3'd1;
  localparam logic [CMD_W-1:0] CMD_GO    = 3'd2;
  localparam logic [CMD_W-1:0] CMD_SLEEP = 3'd3;
  localparam logic [CMD_W-1:0] CMD_WAKE  = 3'd4;

  // request state per handshake lane: 0 lock, 1 release, 2 sr entry, 3 sr exit
  localparam opstate_e REQ_ST [N_REQ] = '{ST_CFG_REQ, ST_ACC_REQ, ST_LP_ENT, ST_LP_EXIT};
  // stable state reached when lane's ack lands
  localparam opstate_e SETTLE_ST [N_REQ] = '{ST_CFG, ST_ACC, ST_LP, ST_ACC};
endpackage

// File: rtl/mcop_cmd_decode.sv
module mcop_cmd_decode
  import mcop_pkg::*;
(
  input  opstate_e         cur_state,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             take,
  output opstate_e         tgt_state
);
  // legal command table; everything else is dropped
  always_comb begin
    take      = 1'b0;
    tgt_state = cur_state;
    if (cmd_valid) begin
      unique case (cur_state)
        ST_INIT: if (cmd_code == CMD_CFG) begin
          take = 1'b1; tgt_state = ST_CFG_REQ;
        end
        ST_CFG: if (cmd_code == CMD_GO) begin
          take = 1'b1; tgt_state = ST_ACC_REQ;
        end
        ST_ACC: begin
          if (cmd_code == CMD_CFG) begin
            take = 1'b1; tgt_state = ST_CFG_REQ;
          end else if (cmd_code == CMD_SLEEP) begin
            take = 1'b1; tgt_state = ST_LP_ENT;
          end
        end
        ST_LP: if (cmd_code == CMD_WAKE) begin
          take = 1'b1; tgt_state = ST_LP_EXIT;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mcop_ack_select.sv
module mcop_ack_select
  import mcop_pkg::*;
(
  input  opstate_e         cur_state,
  input  logic [N_REQ-1:0] ack_vec,
  output logic             in_req,
  output logic             ack_hit,
  output opstate_e         settle_state
);
  logic [N_REQ-1:0] lane_sel;

  generate
    for (genvar i = 0; i < N_REQ; i++) begin : g_lane
      assign lane_sel[i] = (cur_state == REQ_ST[i]);
    end
  endgenerate

  always_comb begin
    in_req       = |lane_sel;
    ack_hit      = |(lane_sel & ack_vec);
    settle_state = cur_state;
    for (int i = 0; i < N_REQ; i++) begin
      if (lane_sel[i]) settle_state = SETTLE_ST[i];
    end
  end
endmodule

// File: rtl/mcop_req_regs.sv
module mcop_req_regs
  import mcop_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  opstate_e         nxt_state,
  output logic [N_REQ-1:0] req_q
);
  generate
    for (genvar i = 0; i < N_REQ; i++) begin : g_req
      always_ff @(posedge clk) begin
        if (rst) req_q[i] <= 1'b0;
        else     req_q[i] <= (nxt_state == REQ_ST[i]);
      end
    end
  endgenerate
endmodule

// File: rtl/mc_opstate.sv
module mc_opstate
  import mcop_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             cfg_lock_ack,
  input  logic             cfg_rel_ack,
  input  logic             sr_enter_ack,
  input  logic             sr_exit_ack,
  output logic [ST_W-1:0]  status,
  output logic             cfg_lock_req,
  output logic             cfg_rel_req,
  output logic             sr_enter_req,
  output logic             sr_exit_req
);
  opstate_e         state_q, nxt_state, tgt_state, settle_state;
  logic             take, in_req, ack_hit;
  logic [N_REQ-1:0] req_q;
  logic [N_REQ-1:0] ack_vec;

  assign ack_vec = {sr_exit_ack, sr_enter_ack, cfg_rel_ack, cfg_lock_ack};

  mcop_cmd_decode u_dec (
    .cur_state (state_q),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .take      (take),
    .tgt_state (tgt_state)
  );

  mcop_ack_select u_ack (
    .cur_state    (state_q),
    .ack_vec      (ack_vec),
    .in_req       (in_req),
    .ack_hit      (ack_hit),
    .settle_state (settle_state)
  );

  // request states only leave on ack; stable states only leave on a taken command
  always_comb begin
    if (in_req) nxt_state = ack_hit ? settle_state : state_q;
    else        nxt_state = take ? tgt_state : state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_INIT;
    else     state_q <= nxt_state;
  end

  mcop_req_regs u_req (
    .clk       (clk),
    .rst       (rst),
    .nxt_state (nxt_state),
    .req_q     (req_q)
  );

  assign status       = state_q;
  assign cfg_lock_req = req_q[0];
  assign cfg_rel_req  = req_q[1];
  assign sr_enter_req = req_q[2];
  assign sr_exit_req  = req_q[3];

  assert_req_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_lock_req, cfg_rel_req, sr_enter_req, sr_exit_req}));

  assert_lock_req_match_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_lock_req == (status == ST_CFG_REQ));

  assert_exit_req_match_R8: assert property (@(posedge clk) disable iff (rst)
    sr_exit_req == (status == ST_LP_EXIT));

  assert_cfg_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (status == ST_CFG_REQ) |-> ($past(status) == ST_INIT || $past(status) == ST_ACC ||
                                $past(status) == ST_CFG_REQ));

  assert_go_settle_R3: assert property (@(posedge clk) disable iff (rst)
    (status == ST_ACC_REQ && cfg_rel_ack) |=> (status == ST_ACC));

  assert_sleep_from_access_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_enter_req) |-> ($past(status) == ST_ACC));

  assert_wake_to_access_R5: assert property (@(posedge clk) disable iff (rst)
    (status == ST_LP_EXIT && sr_exit_ack) |=> (status == ST_ACC));

  assert_hold_without_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (status == ST_CFG_REQ && !cfg_lock_ack) |=> (status == ST_CFG_REQ));

  assert_lp_ignores_R7: assert property (@(posedge clk) disable iff (rst)
    (status == ST_LP && !(cmd_valid && cmd_code == CMD_WAKE)) |=> (status == ST_LP));
endmodule

// File: tb/mc_opstate_tb.sv
`timescale 1ns/1ps
module mc_opstate_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic       cfg_lock_ack = 1'b0, cfg_rel_ack = 1'b0, sr_enter_ack = 1'b0, sr_exit_ack = 1'b0;
  logic [2:0] status;
  logic       cfg_lock_req, cfg_rel_req, sr_enter_req, sr_exit_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mc_opstate u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cfg_lock_ack(cfg_lock_ack), .cfg_rel_ack(cfg_rel_ack),
    .sr_enter_ack(sr_enter_ack), .sr_exit_ack(sr_exit_ack),
    .status(status), .cfg_lock_req(cfg_lock_req), .cfg_rel_req(cfg_rel_req),
    .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int reqs();
    return {28'd0, sr_exit_req, sr_enter_req, cfg_rel_req, cfg_lock_req};
  endfunction

  task automatic send(input logic [2:0] code);
    cmd_valid = 1'b1;
    cmd_code  = code;
    step();
    cmd_valid = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    step();
    chk(status, 0, "R1 status in reset");
    chk(reqs(), 0, "R1 requests in reset");
    rst = 1'b0;
    step();
    chk(status, 0, "R1 status after reset");
    chk(reqs(), 0, "R1 requests after reset");
  endtask

  // R7: only config is legal in init
  task automatic t_init_illegal();
    send(3'd2); chk(status, 0, "R7 go in init");
    send(3'd3); chk(status, 0, "R7 sleep in init");
    send(3'd4); chk(status, 0, "R7 wakeup in init");
    send(3'd0); chk(status, 0, "R7 init cmd in init");
    send(3'd5); chk(status, 0, "R7 code5 in init");
    send(3'd7); chk(status, 0, "R7 code7 in init");
    chk(reqs(), 0, "R7 no request after illegal cmds");
  endtask

  // R2, R6, R7, R8, R9
  task automatic t_init_to_cfg();
    send(3'd1);
    chk(status, 2, "R2 config cmd from init");
    chk(reqs(), 1, "R8 only lock req in status 2");
    step(); step(); step();
    chk(status, 2, "R6 hold in config request without ack");
    cfg_rel_ack = 1'b1; step(); cfg_rel_ack = 1'b0;
    chk(status, 2, "R9 release ack ignored in status 2");
    send(3'd3);
    chk(status, 2, "R7 command during request state");
    cfg_lock_ack = 1'b1; step(); cfg_lock_ack = 1'b0;
    chk(status, 1, "R2 lock ack settles in config");
    chk(reqs(), 0, "R8 lock req drops in config");
  endtask

  // R3, R7
  task automatic t_cfg_to_acc();
    send(3'd3); chk(status, 1, "R7 sleep in config");
    send(3'd4); chk(status, 1, "R7 wakeup in config");
    send(3'd1); chk(status, 1, "R7 config in config");
    send(3'd2);
    chk(status, 4, "R3 go from config");
    chk(reqs(), 2, "R8 only release req in status 4");
    cfg_rel_ack = 1'b1; step(); cfg_rel_ack = 1'b0;
    chk(status, 3, "R3 release ack settles in access");
    chk(reqs(), 0, "R8 no req in access");
  endtask

  // R4, R6, R7, R9
  task automatic t_sleep();
    send(3'd4); chk(status, 3, "R7 wakeup in access");
    sr_enter_ack = 1'b1;
    send(3'd3);
    chk(status, 6, "R6 entry request lasts one cycle with early ack");
    chk(reqs(), 4, "R8 only entry req in status 6");
    step();
    sr_enter_ack = 1'b0;
    chk(status, 5, "R4 entry ack settles in low power");
    send(3'd1); chk(status, 5, "R7 config in low power");
    send(3'd2); chk(status, 5, "R7 go in low power");
    sr_exit_ack = 1'b1; step(); sr_exit_ack = 1'b0;
    chk(status, 5, "R9 exit ack outside exit request");
  endtask

  // R5, R2
  task automatic t_wake_then_cfg();
    send(3'd4);
    chk(status, 7, "R5 wakeup from low power");
    chk(reqs(), 8, "R8 only exit req in status 7");
    step();
    chk(status, 7, "R6 hold in exit request without ack");
    sr_exit_ack = 1'b1; step(); sr_exit_ack = 1'b0;
    chk(status, 3, "R5 wake lands in access");
    send(3'd1);
    chk(status, 2, "R2 config cmd from access");
    cfg_lock_ack = 1'b1; step(); cfg_lock_ack = 1'b0;
    chk(status, 1, "R2 config reached from access");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_init_illegal();
    t_init_to_cfg();
    t_cfg_to_acc();
    t_sleep();
    t_wake_then_cfg();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule